// File: doc/BRIEF.md
# Conversion Result Compare Gate

This block sits between a converter's final result and its result register. Each time a conversion finishes, the block tests the result against two programmable bounds, A and B. It then decides whether the result is kept and reported as complete, or dropped. A dropped result leaves the stored value and the completion pulse untouched, so a converter running back to back conversions keeps going until a result passes.

Three configuration bits set the test. `cmp_en` turns the test on. With `cmp_rng` clear, the test is a single threshold against A. With `cmp_rng` set, the test is a window: it is an inside-window test when A is not above B, and an outside-window test when A is above B. `cmp_gt` picks the direction of the threshold test, and in window mode it picks whether the bounds count as passing. A differential result and both bounds are compared as two's complement numbers. A single-ended result and both bounds are compared as unsigned numbers.

Top module: `adc_cmp_gate`

## Requirements
- R1: With `cmp_en` low, every result presented with `res_valid` high passes, whatever the bounds and other bits hold.
- R2: With `cmp_en` high, `cmp_rng` low and `cmp_gt` high, a result passes exactly when it is greater than or equal to A.
- R3: With `cmp_en` high, `cmp_rng` low and `cmp_gt` low, a result passes exactly when it is strictly less than A.
- R4: With `cmp_en` and `cmp_rng` high, `cmp_gt` high and A not above B, a result passes exactly when A <= result <= B.
- R5: With `cmp_en` and `cmp_rng` high, `cmp_gt` low and A not above B, a result passes exactly when A < result < B.
- R6: With `cmp_en` and `cmp_rng` high, `cmp_gt` high and A above B, a result passes exactly when result <= B or result >= A.
- R7: With `cmp_en` and `cmp_rng` high, `cmp_gt` low and A above B, a result passes exactly when result < B or result > A.
- R8: When `res_diff` is high, the result and both bounds are read as two's complement, so 0x8000 is the smallest value at the default width. When `res_diff` is low, all three are read as unsigned, and this applies to the A/B ordering as well.
- R9: `store_ok` is combinational and is high only in a cycle where `res_valid` is high and the result passes.
- R10: A passing result appears on `out_data` from the clock edge that ends its valid cycle. In the cycle after that edge, `out_done` is high for exactly one cycle.
- R11: A failing result leaves `out_data` unchanged and raises no `out_done`. A cycle with `res_valid` low has the same effect.
- R12: While `rst_n` is low, `out_data` reads zero and `out_done` reads low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Final conversion result is present this cycle |
| res_data | input | W | Final conversion result |
| res_diff | input | 1 | Result is differential (signed compare) |
| cmp_en | input | 1 | Compare test enabled |
| cmp_gt | input | 1 | Threshold direction / inclusive bounds |
| cmp_rng | input | 1 | Window test instead of threshold |
| thr_a | input | W | Bound A |
| thr_b | input | W | Bound B |
| store_ok | output | 1 | Result passes and may be stored |
| out_data | output | W | Last accepted result |
| out_done | output | 1 | One-cycle pulse after an accepted result |

## Verification
A wrong mode decode or a wrong sign interpretation appears on `store_ok` in the same cycle as the offending result. The bench probes each test exactly at its bounds, one step inside them and one step outside them. A fault in the hold register appears one edge later: either as `out_data` changing after a rejected result, or as a missing or stretched `out_done` pulse. Results that sit between bounds whose signed and unsigned orderings disagree show a wrong signedness choice straight away.

// File: rtl/adc_cmp_pkg.sv
package adc_cmp_pkg;
  // Which pass test applies to the current result
  typedef enum logic [2:0] {
    TEST_ALL     = 3'd0,
    TEST_GE      = 3'd1,
    TEST_LT      = 3'd2,
    TEST_IN_INC  = 3'd3,
    TEST_IN_EXC  = 3'd4,
    TEST_OUT_INC = 3'd5,
    TEST_OUT_EXC = 3'd6
  } test_e;

  localparam int NUM_REL = 3;  // r vs A, r vs B, B vs A
endpackage

// File: rtl/adc_cmp_relate.sv
module adc_cmp_relate #(
  parameter int W = 16
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         sgn,
  output logic         lt,
  output logic         eq
);
  localparam int EW = W + 1;

  logic [EW-1:0] lhs_x, rhs_x;

  // One extra bit: a copy of the sign in signed mode, zero otherwise
  always_comb begin
    lhs_x = {sgn & lhs[W-1], lhs};
    rhs_x = {sgn & rhs[W-1], rhs};
    lt    = $signed(lhs_x) < $signed(rhs_x);
    eq    = (lhs == rhs);
  end
endmodule

// File: rtl/adc_cmp_select.sv
module adc_cmp_select
  import adc_cmp_pkg::*;
(
  input  logic  en,
  input  logic  gt,
  input  logic  rng,
  input  logic  a_above_b,
  output test_e test
);
  always_comb begin
    if (!en)             test = TEST_ALL;
    else if (!rng)       test = gt ? TEST_GE : TEST_LT;
    else if (!a_above_b) test = gt ? TEST_IN_INC : TEST_IN_EXC;
    else                 test = gt ? TEST_OUT_INC : TEST_OUT_EXC;
  end
endmodule

// File: rtl/adc_cmp_verdict.sv
module adc_cmp_verdict
  import adc_cmp_pkg::*;
(
  input  test_e test,
  input  logic  r_lt_a,
  input  logic  r_eq_a,
  input  logic  r_lt_b,
  input  logic  r_eq_b,
  output logic  pass
);
  logic ge_a, gt_a, le_b;

  always_comb begin
    ge_a = !r_lt_a;
    gt_a = !r_lt_a && !r_eq_a;
    le_b = r_lt_b || r_eq_b;
    unique case (test)
      TEST_ALL:     pass = 1'b1;
      TEST_GE:      pass = ge_a;
      TEST_LT:      pass = r_lt_a;
      TEST_IN_INC:  pass = ge_a && le_b;
      TEST_IN_EXC:  pass = gt_a && r_lt_b;
      TEST_OUT_INC: pass = le_b || ge_a;
      TEST_OUT_EXC: pass = r_lt_b || gt_a;
      default:      pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_cmp_gate.sv
module adc_cmp_gate
  import adc_cmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         res_valid,
  input  logic [W-1:0] res_data,
  input  logic         res_diff,
  input  logic         cmp_en,
  input  logic         cmp_gt,
  input  logic         cmp_rng,
  input  logic [W-1:0] thr_a,
  input  logic [W-1:0] thr_b,
  output logic         store_ok,
  output logic [W-1:0] out_data,
  output logic         out_done
);
  logic [W-1:0]       rel_lhs [NUM_REL];
  logic [W-1:0]       rel_rhs [NUM_REL];
  logic [NUM_REL-1:0] rel_lt, rel_eq;

  // Pairs: 0 = result vs A, 1 = result vs B, 2 = B vs A
  assign rel_lhs[0] = res_data;
  assign rel_rhs[0] = thr_a;
  assign rel_lhs[1] = res_data;
  assign rel_rhs[1] = thr_b;
  assign rel_lhs[2] = thr_b;
  assign rel_rhs[2] = thr_a;

  for (genvar g = 0; g < NUM_REL; g++) begin : g_rel
    adc_cmp_relate #(.W(W)) u_rel (
      .lhs (rel_lhs[g]),
      .rhs (rel_rhs[g]),
      .sgn (res_diff),
      .lt  (rel_lt[g]),
      .eq  (rel_eq[g])
    );
  end

  test_e test;
  logic  pass;

  adc_cmp_select u_sel (
    .en        (cmp_en),
    .gt        (cmp_gt),
    .rng       (cmp_rng),
    .a_above_b (rel_lt[2]),
    .test      (test)
  );

  adc_cmp_verdict u_ver (
    .test   (test),
    .r_lt_a (rel_lt[0]),
    .r_eq_a (rel_eq[0]),
    .r_lt_b (rel_lt[1]),
    .r_eq_b (rel_eq[1]),
    .pass   (pass)
  );

  assign store_ok = res_valid && pass;

  // Next state
  logic [W-1:0] data_d;
  logic         done_d;

  always_comb begin
    data_d = out_data;
    if (store_ok) data_d = res_data;
    done_d = store_ok;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_done <= 1'b0;
    end else begin
      out_data <= data_d;
      out_done <= done_d;
    end
  end
endmodule

// File: rtl/adc_cmp_gate_chk.sv
module adc_cmp_gate_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         res_valid,
  input logic [W-1:0] res_data,
  input logic         res_diff,
  input logic         cmp_en,
  input logic         cmp_gt,
  input logic         cmp_rng,
  input logic [W-1:0] thr_a,
  input logic [W-1:0] store_ok_dummy_unused_w,
  input logic         store_ok,
  input logic [W-1:0] out_data,
  input logic         out_done
);
  // R1
  disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !cmp_en) |-> store_ok);

  // R2
  unsigned_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cmp_en && !cmp_rng && cmp_gt && !res_diff)
      |-> (store_ok == (res_data >= thr_a)));

  // R9
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_ok |-> res_valid);

  // R10
  accept_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_ok |=> (out_done && out_data == $past(res_data)));

  // R11
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !store_ok |=> (!out_done && $stable(out_data)));

  // R12
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (out_data == '0 && !out_done);
    end
  end

  logic unused_w;
  assign unused_w = ^store_ok_dummy_unused_w;
endmodule

bind adc_cmp_gate adc_cmp_gate_chk #(.W(W)) u_chk (
  .clk                     (clk),
  .rst_n                   (rst_n),
  .res_valid               (res_valid),
  .res_data                (res_data),
  .res_diff                (res_diff),
  .cmp_en                  (cmp_en),
  .cmp_gt                  (cmp_gt),
  .cmp_rng                 (cmp_rng),
  .thr_a                   (thr_a),
  .store_ok_dummy_unused_w (thr_b),
  .store_ok                (store_ok),
  .out_data                (out_data),
  .out_done                (out_done)
);

// File: tb/sim_adc_cmp_gate.sv
module sim_adc_cmp_gate;
  localparam int W = 16;

  logic         clk;
  logic         rst_n;
  logic         res_valid;
  logic [W-1:0] res_data;
  logic         res_diff;
  logic         cmp_en, cmp_gt, cmp_rng;
  logic [W-1:0] thr_a, thr_b;
  logic         store_ok;
  logic [W-1:0] out_data;
  logic         out_done;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] held = '0;

  adc_cmp_gate #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .res_diff(res_diff), .cmp_en(cmp_en), .cmp_gt(cmp_gt), .cmp_rng(cmp_rng),
    .thr_a(thr_a), .thr_b(thr_b), .store_ok(store_ok), .out_data(out_data),
    .out_done(out_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setup(input logic en, input logic gt, input logic rng,
                       input logic diff, input logic [W-1:0] a,
                       input logic [W-1:0] b);
    @(negedge clk);
    cmp_en = en; cmp_gt = gt; cmp_rng = rng; res_diff = diff;
    thr_a = a; thr_b = b;
  endtask

  // Present one result, check the gate, then the register one edge later
  task automatic try_one(input string req, input logic [W-1:0] r,
                         input logic exp_pass);
    @(negedge clk);
    res_data = r; res_valid = 1'b1;
    #1;
    check(req, {{(W-1){1'b0}}, store_ok}, {{(W-1){1'b0}}, exp_pass});
    @(negedge clk);
    res_valid = 1'b0;
    if (exp_pass) held = r;
    check({req, " done"}, {{(W-1){1'b0}}, out_done}, {{(W-1){1'b0}}, exp_pass});
    check({req, " data"}, out_data, held);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; res_valid = 1'b0; res_data = '0; res_diff = 1'b0;
    cmp_en = 1'b0; cmp_gt = 1'b0; cmp_rng = 1'b0; thr_a = '0; thr_b = '0;
    repeat (3) @(negedge clk);
    check("R12 data", out_data, '0);
    check("R12 done", {{(W-1){1'b0}}, out_done}, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_disabled();
    setup(1'b0, 1'b1, 1'b1, 1'b0, 16'd100, 16'd200);
    try_one("R1", 16'd5, 1'b1);
    try_one("R1", 16'hEA60, 1'b1);
    try_one("R1", 16'd150, 1'b1);
  endtask

  task automatic t_idle();
    // R9 / R11: no valid, no store, register holds
    setup(1'b0, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0);
    @(negedge clk);
    res_data = 16'h1234; res_valid = 1'b0;
    #1;
    check("R9", {{(W-1){1'b0}}, store_ok}, '0);
    @(negedge clk);
    check("R11 idle done", {{(W-1){1'b0}}, out_done}, '0);
    check("R11 idle data", out_data, held);
  endtask

  task automatic t_ge();
    setup(1'b1, 1'b1, 1'b0, 1'b0, 16'd100, 16'd7);
    try_one("R2", 16'd99, 1'b0);
    try_one("R2", 16'd100, 1'b1);
    try_one("R2", 16'd101, 1'b1);
  endtask

  task automatic t_lt();
    setup(1'b1, 1'b0, 1'b0, 1'b0, 16'd100, 16'd7);
    try_one("R3", 16'd99, 1'b1);
    try_one("R3", 16'd100, 1'b0);
    try_one("R3", 16'd101, 1'b0);
  endtask

  task automatic t_in_inc();
    setup(1'b1, 1'b1, 1'b1, 1'b0, 16'd100, 16'd200);
    try_one("R4", 16'd100, 1'b1);
    try_one("R4", 16'd200, 1'b1);
    try_one("R4", 16'd99, 1'b0);
    try_one("R4", 16'd201, 1'b0);
    // equal bounds: only that one value passes
    setup(1'b1, 1'b1, 1'b1, 1'b0, 16'd50, 16'd50);
    try_one("R4 eq", 16'd50, 1'b1);
    try_one("R4 eq", 16'd51, 1'b0);
  endtask

  task automatic t_in_exc();
    setup(1'b1, 1'b0, 1'b1, 1'b0, 16'd100, 16'd200);
    try_one("R5", 16'd100, 1'b0);
    try_one("R5", 16'd200, 1'b0);
    try_one("R5", 16'd101, 1'b1);
    try_one("R5", 16'd199, 1'b1);
  endtask

  task automatic t_out_inc();
    setup(1'b1, 1'b1, 1'b1, 1'b0, 16'd200, 16'd100);
    try_one("R6", 16'd100, 1'b1);
    try_one("R6", 16'd200, 1'b1);
    try_one("R6", 16'd150, 1'b0);
    try_one("R6", 16'd50, 1'b1);
    try_one("R6", 16'd250, 1'b1);
  endtask

  task automatic t_out_exc();
    setup(1'b1, 1'b0, 1'b1, 1'b0, 16'd200, 16'd100);
    try_one("R7", 16'd100, 1'b0);
    try_one("R7", 16'd200, 1'b0);
    try_one("R7", 16'd99, 1'b1);
    try_one("R7", 16'd201, 1'b1);
    try_one("R7", 16'd150, 1'b0);
  endtask

  task automatic t_signed();
    // A = -16 signed, 65520 unsigned
    setup(1'b1, 1'b1, 1'b0, 1'b1, 16'hFFF0, 16'd0);
    try_one("R8 signed ge", 16'h0005, 1'b1);
    try_one("R8 signed min", 16'h8000, 1'b0);
    setup(1'b1, 1'b1, 1'b0, 1'b0, 16'hFFF0, 16'd0);
    try_one("R8 unsigned ge", 16'h0005, 1'b0);
    // Window -256..256 signed; unsigned ordering makes it outside
    setup(1'b1, 1'b1, 1'b1, 1'b1, 16'hFF00, 16'h0100);
    try_one("R8 signed in", 16'h0080, 1'b1);
    try_one("R8 signed in", 16'hFF80, 1'b1);
    try_one("R8 signed in", 16'h8000, 1'b0);
    setup(1'b1, 1'b1, 1'b1, 1'b0, 16'hFF00, 16'h0100);
    try_one("R8 unsigned out", 16'h0080, 1'b1);
    try_one("R8 unsigned out", 16'h8000, 1'b0);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_idle();
    t_ge();
    t_lt();
    t_in_inc();
    t_in_exc();
    t_out_inc();
    t_out_exc();
    t_signed();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule